// File: doc/BRIEF.md
# Real-Time Clock with Snapshot Read and Watchdog

This block keeps a free-running time count for the chip. A prescaler divides the system clock so that a time counter advances once every `PRESCALE` cycles. The counter wraps to zero when it overflows. Software reads the time as three byte-wide registers. Reading the lowest byte freezes the middle and top bytes in a snapshot register, so the two later byte reads belong to the same instant as the first one. A watchdog timer runs beside the clock and gives a one-cycle timeout pulse if nobody restarts it in time.

Both the clock and the watchdog are reset by a write to a strobe address, and the data written there is ignored. While the power-down input is high, the clock keeps counting but reads are blocked. A blocked read returns zero and leaves the snapshot untouched.

Reads are answered one cycle after `bus_rd` by a small response state machine. It has two states. `RSP_NONE` is idle and `RSP_DATA` is driving a response. The transition *accept* (`RSP_NONE`→`RSP_DATA`, or staying in `RSP_DATA`) is taken when `bus_rd` is high. The transition *release* (`RSP_DATA`→`RSP_NONE`) is taken when `bus_rd` is low.

Top module: `rtc_snapshot_clock`

## Requirements
- R1: While reset is held and just after it is released, `rd_data` is 0, `rd_valid` is 0 and `wd_timeout` is 0. The time counter and the snapshot register start at zero, so a middle-byte read before any low-byte read returns 0.
- R2: The time counter advances once every `PRESCALE` clock cycles. A low-byte read at edge e returns bits 7..0 of floor((e-1-w)/PRESCALE), where w is the edge of the last clock-reset write.
- R3: The counter is `CNT_W` bits wide (24 by default) and wraps from its all-ones value to zero.
- R4: A write to address 3 clears both the prescaler phase and the counter at that edge, whatever value is on `bus_wdata`.
- R5: Address 0 returns the live low byte. Address 1 returns snapshot bits 15..8 and address 2 returns snapshot bits 23..16. Each byte is placed on `rd_data[15:8]` with `rd_data[7:0]` = 0. Data appears one cycle after `bus_rd`, with `rd_valid` high in that cycle. Any other address reads 0.
- R6: A read of address 0 captures the upper counter bytes into the snapshot. The snapshot then keeps that value until the next accepted address-0 read, even while the counter moves on.
- R7: While `pwr_dn` is high, a read returns 0 (with `rd_valid` still high) and does not update the snapshot. The counter keeps advancing throughout.
- R8: If the watchdog is not restarted, `wd_timeout` pulses high for exactly one cycle `WD_LIMIT` cycles after the last restart. The watchdog then begins a new period from zero.
- R9: A write to address 4 restarts the watchdog period, whatever value is on `bus_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe, one per cycle |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address (0 low, 1 mid, 2 high, 3 clock clear, 4 watchdog restart) |
| bus_wdata | input | 16 | Write data, ignored by every address |
| pwr_dn | input | 1 | Power-down: blocks reads, counting continues |
| rd_data | output | 16 | Read response, byte on bits 15..8 |
| rd_valid | output | 1 | High in the cycle `rd_data` holds a response |
| wd_timeout | output | 1 | One-cycle watchdog expiry pulse |

## Verification
The time function is tried with a set of idle gaps between a clock clear and a low-byte read. The gaps fall just before, on and just past multiples of the prescale ratio, which separates an off-by-one in the divider from a correct one. A second instance with a narrow counter and no prescaling is driven past its overflow, and its bytes are read across a byte carry. This shows the snapshot holding while the live value has moved on, and shows the wrap. Reads during power-down, followed by reads after wake-up, show that the snapshot stayed frozen while the count did not. Watchdog runs with and without a late restart show whether the pulse is tied to the latest restart or to the first one.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int BYTE_W     = 8;
    localparam int TIME_BYTES = 3;
    localparam int BUS_W      = 16;

    typedef enum logic [2:0] {
        REG_TIME_LO  = 3'd0,
        REG_TIME_MID = 3'd1,
        REG_TIME_HI  = 3'd2,
        REG_CLK_CLR  = 3'd3,
        REG_WD_KICK  = 3'd4
    } rtc_addr_e;

    typedef enum logic {
        RSP_NONE = 1'b0,
        RSP_DATA = 1'b1
    } rsp_state_e;

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);

    generate
        if (PRESCALE <= 1) begin : g_bypass
            logic unused_inputs;
            assign unused_inputs = clr ^ clk ^ rst_n;
            assign tick = 1'b1;
        end else begin : g_div
            localparam int DIV_W = $clog2(PRESCALE);
            localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(PRESCALE - 1);

            logic [DIV_W-1:0] div_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    div_q <= '0;
                end else if (clr || (div_q == DIV_LAST)) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end

            assign tick = (div_q == DIV_LAST);

            // R2
            tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);

            // R4
            clr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
                clr |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && tick) |=> (count_q == $past(count_q) + CNT_W'(1)));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick) |=> $stable(count_q));

    // R4
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count_q == '0));

endmodule

// File: rtl/rtc_watchdog.sv
module rtc_watchdog #(
    parameter int WD_LIMIT = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic timeout
);

    localparam int WD_W = (WD_LIMIT > 2) ? $clog2(WD_LIMIT) : 1;
    localparam logic [WD_W-1:0] WD_LAST = WD_W'(WD_LIMIT - 1);

    logic [WD_W-1:0] wd_q;
    logic            to_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_q <= '0;
            to_q <= 1'b0;
        end else if (kick) begin
            wd_q <= '0;
            to_q <= 1'b0;
        end else if (wd_q == WD_LAST) begin
            wd_q <= '0;
            to_q <= 1'b1;
        end else begin
            wd_q <= wd_q + 1'b1;
            to_q <= 1'b0;
        end
    end

    assign timeout = to_q;

    // R8
    wd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout);

    // R8
    wd_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (wd_q == '0));

    // R9
    wd_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (!timeout && wd_q == '0));

endmodule

// File: rtl/rtc_read_port.sv
module rtc_read_port
    import rtc_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd,
    input  logic [2:0]       addr,
    input  logic             pwr_dn,
    input  logic [CNT_W-1:0] count,
    output logic [BUS_W-1:0] rd_data,
    output logic             rd_valid
);

    localparam int LIVE_W = TIME_BYTES * BYTE_W;
    localparam int SNAP_W = LIVE_W - BYTE_W;

    logic [LIVE_W-1:0] live;
    logic [SNAP_W-1:0] snap_q;
    logic [BUS_W-1:0]  data_q;
    logic              lo_capture;
    rsp_state_e        state_q, state_d;

    assign live       = LIVE_W'(count);
    assign lo_capture = rd && !pwr_dn && (addr == REG_TIME_LO);

    // response state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSP_NONE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: accept / release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSP_NONE: state_d = rd ? RSP_DATA : RSP_NONE;
            RSP_DATA: state_d = rd ? RSP_DATA : RSP_NONE;
            default:  state_d = RSP_NONE;
        endcase
    end

    // state outputs
    always_comb begin
        rd_valid = (state_q == RSP_DATA);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (lo_capture) begin
            snap_q <= live[LIVE_W-1:BYTE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !rd || pwr_dn) begin
            data_q <= '0;
        end else begin
            case (addr)
                REG_TIME_LO:  data_q <= {live[BYTE_W-1:0], 8'h00};
                REG_TIME_MID: data_q <= {snap_q[BYTE_W-1:0], 8'h00};
                REG_TIME_HI:  data_q <= {snap_q[SNAP_W-1:BYTE_W], 8'h00};
                default:      data_q <= '0;
            endcase
        end
    end

    assign rd_data = data_q;

    // R5
    rsp_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rd_valid);

    // R5
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (rd_data == '0 && !rd_valid));

    // R6
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd && addr == REG_TIME_LO) |=> $stable(snap_q));

    // R7
    pd_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> $stable(snap_q));

    // R7
    pd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && pwr_dn) |=> (rd_data == '0));

endmodule

// File: rtl/rtc_snapshot_clock.sv
module rtc_snapshot_clock
    import rtc_pkg::*;
#(
    parameter int PRESCALE = 4,
    parameter int CNT_W    = 24,
    parameter int WD_LIMIT = 40
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    input  logic        pwr_dn,
    output logic [15:0] rd_data,
    output logic        rd_valid,
    output logic        wd_timeout
);

    logic             clk_clr;
    logic             wd_kick;
    logic             tick;
    logic [CNT_W-1:0] count;
    logic             unused_wdata;

    assign clk_clr      = bus_wr && (bus_addr == REG_CLK_CLR);
    assign wd_kick      = bus_wr && (bus_addr == REG_WD_KICK);
    assign unused_wdata = ^bus_wdata;

    rtc_prescaler #(.PRESCALE(PRESCALE)) u_prescaler (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clk_clr),
        .tick (tick)
    );

    rtc_time_counter #(.CNT_W(CNT_W)) u_counter (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clk_clr),
        .tick (tick),
        .count(count)
    );

    rtc_read_port #(.CNT_W(CNT_W)) u_read_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (bus_rd),
        .addr    (bus_addr),
        .pwr_dn  (pwr_dn),
        .count   (count),
        .rd_data (rd_data),
        .rd_valid(rd_valid)
    );

    rtc_watchdog #(.WD_LIMIT(WD_LIMIT)) u_watchdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .kick   (wd_kick),
        .timeout(wd_timeout)
    );

endmodule

// File: tb/test_rtc_snapshot_clock.sv
module test_rtc_snapshot_clock;

    localparam int WD_A  = 40;
    localparam int PRE_A = 4;
    localparam logic [2:0] A_LO = 3'd0, A_MID = 3'd1, A_HI = 3'd2, A_CLR = 3'd3, A_KICK = 3'd4;

    localparam int VEC_N = 6;
    localparam int          VEC_IDLE [VEC_N] = '{0, 3, 4, 7, 9, 21};
    localparam int          VEC_LO_A [VEC_N] = '{0, 0, 1, 1, 2, 5};
    localparam logic [15:0] VEC_DATA [VEC_N] = '{16'h0000, 16'hFFFF, 16'h1234, 16'h8001, 16'hA5A5, 16'h0F0F};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0, pwr_dn = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] rd_data_a, rd_data_b;
    logic        rd_valid_a, rd_valid_b, wd_to_a, wd_to_b;

    int n_chk = 0, n_err = 0, ecnt = 0, clr_w = 0, kick_w = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) ecnt <= ecnt + 1;

    rtc_snapshot_clock #(.PRESCALE(PRE_A), .CNT_W(24), .WD_LIMIT(WD_A)) i_rtc_snapshot_clock (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .pwr_dn(pwr_dn), .rd_data(rd_data_a), .rd_valid(rd_valid_a),
        .wd_timeout(wd_to_a));

    rtc_snapshot_clock #(.PRESCALE(1), .CNT_W(10), .WD_LIMIT(16)) i_rtc_wrap (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .pwr_dn(pwr_dn), .rd_data(rd_data_b), .rd_valid(rd_valid_b),
        .wd_timeout(wd_to_b));

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // entered and left at a falling edge
    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        if (a == A_CLR) clr_w = ecnt;
        if (a == A_KICK) kick_w = ecnt;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] da, output logic [15:0] db,
                            output logic va, output int e);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        e = ecnt;
        @(negedge clk);
        bus_rd = 1'b0;
        da = rd_data_a; db = rd_data_b; va = rd_valid_a;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] lane(input int v);
        return {8'(v), 8'h00};
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        logic [15:0] da, db;
        logic va;
        int e;

        // R1 reset state
        idle(3);
        chk("R1 rd_data in reset", rd_data_a, 16'h0);
        chk("R1 rd_valid in reset", {15'b0, rd_valid_a}, 16'h0);
        chk("R1 wd_timeout in reset", {15'b0, wd_to_a}, 16'h0);
        rst_n = 1'b1;
        bus_write(A_CLR, 16'h0000);
        bus_read(A_MID, da, db, va, e);
        chk("R1 snapshot A zero", da, 16'h0);
        chk("R1 snapshot B zero", db, 16'h0);

        // R2 R4 table of idle gaps after a clock clear with varied data
        for (int i = 0; i < VEC_N; i++) begin
            bus_write(A_CLR, VEC_DATA[i]);
            idle(VEC_IDLE[i]);
            bus_read(A_LO, da, db, va, e);
            chk("R2 prescaled low byte A", da, lane(VEC_LO_A[i]));
            chk("R4 clear ignores data, low byte B", db, lane(VEC_IDLE[i]));
            chk("R5 rd_valid on low read", {15'b0, va}, 16'h1);
        end

        // R4 clear mid-count with all-ones data
        idle(13);
        bus_write(A_CLR, 16'hFFFF);
        idle(8);
        bus_read(A_LO, da, db, va, e);
        chk("R4 all-ones clear A", da, lane(2));
        chk("R4 all-ones clear B", db, lane(8));

        // R5 unmapped address
        bus_read(3'd6, da, db, va, e);
        chk("R5 unmapped reads zero", da, 16'h0);
        chk("R5 unmapped rd_valid", {15'b0, va}, 16'h1);

        // R6 snapshot holds across a byte carry
        bus_write(A_CLR, 16'h0000);
        idle(1020);
        bus_read(A_LO, da, db, va, e);
        chk("R6 low at capture B", db, lane(252));
        idle(10);
        bus_read(A_MID, da, db, va, e);
        chk("R6 mid held B", db, lane(3));
        chk("R6 mid held A", da, lane(0));
        bus_read(A_HI, da, db, va, e);
        chk("R6 high held B", db, lane(0));

        // R3 wrap of the narrow counter
        bus_write(A_CLR, 16'h0000);
        idle(1030);
        bus_read(A_LO, da, db, va, e);
        chk("R3 wrapped low B", db, lane(6));
        chk("R2 low A at 1030", da, lane(1));
        bus_read(A_MID, da, db, va, e);
        chk("R3 wrapped mid B", db, lane(0));
        chk("R5 mid A", da, lane(1));

        // R7 power-down
        bus_write(A_CLR, 16'h0000);
        idle(600);
        bus_read(A_LO, da, db, va, e);
        chk("R7 low before sleep B", db, lane(88));
        pwr_dn = 1'b1;
        idle(200);
        bus_read(A_LO, da, db, va, e);
        chk("R7 blocked low A", da, 16'h0);
        chk("R7 blocked low B", db, 16'h0);
        chk("R7 rd_valid when blocked", {15'b0, va}, 16'h1);
        pwr_dn = 1'b0;
        bus_read(A_MID, da, db, va, e);
        chk("R7 snapshot kept B", db, lane(2));
        bus_read(A_LO, da, db, va, e);
        chk("R7 count ran B", db, lane(e - 1 - clr_w));
        chk("R7 count ran A", da, lane((e - 1 - clr_w) / PRE_A));

        // R8 expiry and restart
        bus_write(A_KICK, 16'h0000);
        idle(WD_A - 1);
        chk("R8 no pulse early", {15'b0, wd_to_a}, 16'h0);
        idle(1);
        chk("R8 pulse at limit", {15'b0, wd_to_a}, 16'h1);
        idle(1);
        chk("R8 single cycle", {15'b0, wd_to_a}, 16'h0);
        idle(WD_A - 1);
        chk("R8 next period", {15'b0, wd_to_a}, 16'h1);

        // R9 late restart with arbitrary data
        bus_write(A_KICK, 16'h0000);
        idle(WD_A - 6);
        bus_write(A_KICK, 16'h5A5A);
        idle(5);
        chk("R9 old expiry suppressed", {15'b0, wd_to_a}, 16'h0);
        idle(WD_A - 5);
        chk("R9 expiry from restart", {15'b0, wd_to_a}, 16'h1);

        done = 1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

endmodule